// File: doc/BRIEF.md
# Test-access-port instruction register and decoder

This block is the front end of a serial test port. It tracks the sixteen-state test-access-port controller from the test clock, mode select and active-low port reset inputs. It holds a 4-bit instruction in two stages. A shift stage takes the next opcode serially from the data input. A hold stage keeps the active opcode until the controller reaches Update-IR. The held opcode is decoded into a one-hot choice of two external data registers or a 1-bit bypass register. The chosen register's serial output is routed to the test data output.

Every register action happens on the rising edge that moves the controller into the state named for it. Capture happens on the edge into Capture-IR or Capture-DR. Update happens on the edge into Update-IR or Update-DR. Shifting happens on each edge that enters Shift-IR or Shift-DR, or stays there. With this timing the edge that enters Shift-IR already takes in the opcode's least significant bit. The test data output is retimed on the falling edge and is enabled only while the controller is in a shift state. The block gives external data registers capture, shift and update strobes that are aligned to the same edges. It also gives their select lines.

Top module: `jtag_ir_decoder`

## Requirements
- R1: From Test-Logic-Reset, TMS values 0,1,1,0,0 on five rising edges reach Shift-IR, and `tdo_oe` is high after the falling edge that follows the fifth edge.
- R2: The edge into Capture-IR loads the shift stage with 4'b0001. On the next four shift edges its bits appear on `tdo` least significant bit first, as 1,0,0,0.
- R3: The opcode enters least significant bit first, one bit from `tdi` on each rising edge that enters or stays in Shift-IR. Two more edges with TMS=1 pass through Exit1-IR to Update-IR, and on the edge into Update-IR the opcode becomes the active one.
- R4: Shifting and Exit1-IR leave the active instruction and the select outputs unchanged. They change only on the edge into Update-IR or into Test-Logic-Reset.
- R5: Active opcode 4'b0010 raises `sel_dr1` and 4'b0011 raises `sel_dr2`. Every other opcode, all ones included, raises `sel_byp`. Exactly one select is high at all times.
- R6: With bypass selected, the edge into Capture-DR clears the bypass bit. In Shift-DR, `tdo` first gives that 0 and then each `tdi` bit delayed by one shift edge.
- R7: With `sel_dr1` or `sel_dr2` high, after each Shift-DR edge `tdo` shows the value that the selected register's serial output (`dr1_so` or `dr2_so`) had at that edge.
- R8: Five rising edges with TMS=1 return the controller to Test-Logic-Reset from any state, and the active opcode becomes the bypass opcode 4'b1111.
- R9: `trst_n` low at once forces Test-Logic-Reset and the bypass opcode, and drives `tdo_oe` and `tdo` low.
- R10: `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is high only in Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_oe` is low.
- R11: `dr_capture`, `dr_shift` and `dr_update` are high exactly when the coming rising edge enters Capture-DR, enters or stays in Shift-DR, or enters Update-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous port reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| dr1_so | input | 1 | Serial output of data register 1 |
| dr2_so | input | 1 | Serial output of data register 2 |
| tdo | output | 1 | Serial data out, retimed on falling edge |
| tdo_oe | output | 1 | Output enable for tdo |
| sel_dr1 | output | 1 | Data register 1 selected |
| sel_dr2 | output | 1 | Data register 2 selected |
| sel_byp | output | 1 | Bypass register selected |
| dr_capture | output | 1 | Coming edge enters Capture-DR |
| dr_shift | output | 1 | Coming edge shifts the data path |
| dr_update | output | 1 | Coming edge enters Update-DR |

## Verification
On every cycle the assertions check that the select outputs are one-hot. They check that the active instruction changes only on entry to Update-IR or Test-Logic-Reset, and that five consecutive TMS highs always end in Test-Logic-Reset. They also check that the capture pattern is present in Capture-IR, and that the output enable and idle output level follow the shift states. The serial order of bits shows only in the bench's scenarios. So do the bit-exact capture pattern on the output, the bypass delay and the routing of the external serial outputs. The same holds for the asynchronous reset and the falling-edge retiming, which the bench sees by sampling before and after each falling edge.

// File: rtl/jtag_ir_decoder.sv
module jtag_ir_decoder #(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] OP_DR1 = 4'b0010,
  parameter logic [IR_W-1:0] OP_DR2 = 4'b0011,
  parameter logic [IR_W-1:0] CAP_PAT = 4'b0001
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic dr1_so,
  input  logic dr2_so,
  output logic tdo,
  output logic tdo_oe,
  output logic sel_dr1,
  output logic sel_dr2,
  output logic sel_byp,
  output logic dr_capture,
  output logic dr_shift,
  output logic dr_update
);
  localparam logic [IR_W-1:0] OP_BYP = '1;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR,
    UPD_DR, SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_t;

  tap_t state, nxt;
  logic [IR_W-1:0] ir_sr, ir_hold;
  logic byp_q, so_q;

  always_comb begin
    case (state)
      TLR:     nxt = tms ? TLR    : RTI;
      RTI:     nxt = tms ? SEL_DR : RTI;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms ? UPD_DR : PAU_DR;
      PAU_DR:  nxt = tms ? EX2_DR : PAU_DR;
      EX2_DR:  nxt = tms ? UPD_DR : SH_DR;
      UPD_DR:  nxt = tms ? SEL_DR : RTI;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms ? UPD_IR : PAU_IR;
      PAU_IR:  nxt = tms ? EX2_IR : PAU_IR;
      EX2_IR:  nxt = tms ? UPD_IR : SH_IR;
      default: nxt = tms ? SEL_DR : RTI;
    endcase
  end

  assign sel_dr1 = (ir_hold == OP_DR1);
  assign sel_dr2 = (ir_hold == OP_DR2);
  assign sel_byp = !sel_dr1 && !sel_dr2;

  assign dr_capture = (nxt == CAP_DR);
  assign dr_shift   = (nxt == SH_DR);
  assign dr_update  = (nxt == UPD_DR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state   <= TLR;
      ir_sr   <= CAP_PAT;
      ir_hold <= OP_BYP;
      byp_q   <= 1'b0;
      so_q    <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == CAP_IR) ir_sr <= CAP_PAT;
      else if (nxt == SH_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (nxt == TLR) ir_hold <= OP_BYP;
      else if (nxt == UPD_IR) ir_hold <= ir_sr;
      if (nxt == CAP_DR) byp_q <= 1'b0;
      else if (nxt == SH_DR) byp_q <= tdi;
      if (nxt == SH_IR) so_q <= ir_sr[0];
      else if (nxt == SH_DR) so_q <= sel_dr1 ? dr1_so : sel_dr2 ? dr2_so : byp_q;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_oe <= 1'b0;
      tdo    <= 1'b0;
    end else begin
      tdo_oe <= (state == SH_IR) || (state == SH_DR);
      tdo    <= ((state == SH_IR) || (state == SH_DR)) ? so_q : 1'b0;
    end
  end
endmodule

// File: rtl/jtag_ir_decoder_chk.sv
module jtag_ir_decoder_chk #(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] CAP_PAT = 4'b0001
) (
  input logic tck,
  input logic trst_n,
  input logic tms,
  input logic [3:0] state,
  input logic [IR_W-1:0] ir_sr,
  input logic [IR_W-1:0] ir_hold,
  input logic sel_dr1,
  input logic sel_dr2,
  input logic sel_byp,
  input logic tdo,
  input logic tdo_oe
);
  localparam logic [3:0] S_TLR = 4'd0, S_SH_DR = 4'd4, S_CAP_IR = 4'd10,
                         S_SH_IR = 4'd11, S_UPD_IR = 4'd15;
  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) ones_cnt <= '0;
    else if (!tms) ones_cnt <= '0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  assert_onehot_sel_R5: assert property (@(posedge tck) disable iff (!trst_n)
    $countones({sel_dr1, sel_dr2, sel_byp}) == 1);

  assert_hold_stable_R4: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(ir_hold) |-> (state == S_UPD_IR || state == S_TLR));

  assert_tlr_after_ones_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == 3'd5) |-> (state == S_TLR && sel_byp));

  assert_capture_pattern_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAP_IR) |-> (ir_sr == CAP_PAT));

  assert_oe_in_shift_R10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == S_SH_IR || state == S_SH_DR));

  assert_idle_tdo_R10: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_oe |-> !tdo);
endmodule

bind jtag_ir_decoder jtag_ir_decoder_chk #(.IR_W(IR_W), .CAP_PAT(CAP_PAT)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir_sr(ir_sr),
  .ir_hold(ir_hold), .sel_dr1(sel_dr1), .sel_dr2(sel_dr2), .sel_byp(sel_byp),
  .tdo(tdo), .tdo_oe(tdo_oe)
);

// File: tb/jtag_ir_decoder_tb_top.sv
`timescale 1ns/100ps
module jtag_ir_decoder_tb_top;
  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic dr1_so = 1'b0, dr2_so = 1'b0;
  logic tdo, tdo_oe, sel_dr1, sel_dr2, sel_byp, dr_capture, dr_shift, dr_update;
  int n_chk = 0, n_fail = 0;
  logic pre_cap, pre_sh, pre_up, rise_tdo, rise_oe;
  logic [3:0] cur_op = 4'b1111;

  jtag_ir_decoder dut_i (.*);

  always #2 tck = ~tck;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_sel(input logic [3:0] op);
    if (op == 4'b0010) return 3'b001;
    if (op == 4'b0011) return 3'b010;
    return 3'b100;
  endfunction

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    #0.5;
    pre_cap = dr_capture; pre_sh = dr_shift; pre_up = dr_update;
    @(posedge tck); #0.5;
    rise_tdo = tdo; rise_oe = tdo_oe;
    @(negedge tck); #0.5;
  endtask

  task automatic load_ir(input logic [3:0] op);
    logic [3:0] cap = 4'b0001;
    step(1, 0); step(1, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      step(0, op[i]);
      if (i == 0) begin
        chk("R10 oe before fall", {3'b0, rise_oe}, 4'd0);
        chk("R1 oe in Shift-IR", {3'b0, tdo_oe}, 4'd1);
      end
      chk("R2 capture bit on tdo", {3'b0, tdo}, {3'b0, cap[i]});
      chk("R4 sel during shift", {1'b0, sel_byp, sel_dr2, sel_dr1}, {1'b0, exp_sel(cur_op)});
    end
    step(1, 0);
    chk("R4 sel in Exit1-IR", {1'b0, sel_byp, sel_dr2, sel_dr1}, {1'b0, exp_sel(cur_op)});
    chk("R10 oe off in Exit1-IR", {2'b0, tdo_oe, tdo}, 4'd0);
    step(1, 0);
    cur_op = op;
    chk("R3 R5 sel after Update-IR", {1'b0, sel_byp, sel_dr2, sel_dr1}, {1'b0, exp_sel(op)});
    step(0, 0);
  endtask

  task automatic scan_dr(input int n);
    logic prev = 1'b0;
    logic b, d, e;
    step(1, 0);
    step(0, 0);
    chk("R11 capture strobe", {3'b0, pre_cap}, 4'd1);
    for (int k = 0; k < n; k++) begin
      b = 1'($urandom); d = 1'($urandom);
      dr1_so = b; dr2_so = ~b;
      step(0, d);
      chk("R11 shift strobe", {3'b0, pre_sh}, 4'd1);
      if (exp_sel(cur_op) == 3'b001) begin e = b; chk("R7 dr1 route", {3'b0, tdo}, {3'b0, e}); end
      else if (exp_sel(cur_op) == 3'b010) begin e = ~b; chk("R7 dr2 route", {3'b0, tdo}, {3'b0, e}); end
      else begin e = (k == 0) ? 1'b0 : prev; chk("R6 bypass delay", {3'b0, tdo}, {3'b0, e}); end
      prev = d;
    end
    step(1, 0);
    chk("R11 no shift on exit", {3'b0, pre_sh}, 4'd0);
    step(1, 0);
    chk("R11 update strobe", {3'b0, pre_up}, 4'd1);
    step(0, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0421));
    #5;
    chk("R9 reset sel", {1'b0, sel_byp, sel_dr2, sel_dr1}, 4'b0100);
    chk("R9 reset tdo", {2'b0, tdo_oe, tdo}, 4'd0);
    @(negedge tck); #0.5;
    trst_n = 1'b1;
    step(0, 0);
    load_ir(4'b1100);
    load_ir(4'b0010); scan_dr(5);
    load_ir(4'b0011); scan_dr(5);
    load_ir(4'b1111); scan_dr(6);
    for (int it = 0; it < 16; it++) begin
      logic [3:0] op;
      op = 4'($urandom);
      if (it % 4 == 1) op = 4'b0010;
      if (it % 4 == 2) op = 4'b0011;
      load_ir(op);
      scan_dr(4);
    end
    for (int it = 0; it < 4; it++) begin
      load_ir(4'b0010);
      for (int w = 0; w < 7; w++) step(1'($urandom), 1'($urandom));
      for (int w = 0; w < 5; w++) step(1, 0);
      chk("R8 bypass after five ones", {1'b0, sel_byp, sel_dr2, sel_dr1}, 4'b0100);
      cur_op = 4'b1111;
      step(0, 0);
      load_ir(4'b0011);
      chk("R8 load works after reset walk", {3'b0, sel_dr2}, 4'd1);
    end
    step(1, 0); step(0, 0); step(0, 1);
    chk("R9 oe before trst", {3'b0, tdo_oe}, 4'd1);
    #0.3 trst_n = 1'b0;
    #0.5;
    chk("R9 async sel", {1'b0, sel_byp, sel_dr2, sel_dr1}, 4'b0100);
    chk("R9 async tdo", {2'b0, tdo_oe, tdo}, 4'd0);
    @(negedge tck); #0.5;
    trst_n = 1'b1;
    cur_op = 4'b1111;
    step(0, 0);
    load_ir(4'b0010);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule